// File: doc/BRIEF.md
# Keyed Configuration Blob Access Port

This block is a small memory-mapped slave that hands out configuration blobs one byte stream at a time. Software writes a 16-bit key into a selector register, which picks one internal blob and rewinds a byte cursor to the start of it. Each access to the data register then moves the next bytes of that blob across the bus. A blob that is writable can be filled through the same data register.

The data register takes 1, 2, 4 or 8 byte accesses. A wide access is treated as a burst of byte accesses bundled into one bus cycle. The lane at the lowest address carries the byte that would have moved first, and each higher lane carries the byte that follows it. Three blobs are built in. One holds a presence signature. One holds a little-endian revision word. The third is a zero-initialised scratch area that software can write.

Requests use a valid/ready handshake that is always ready. A read returns its data on the response port one clock after the request is accepted.

Top module: `cfgblob_port`

## Requirements
- R1: After reset the response valid is low, the selected key is 0x0000, the cursor is 0 and every scratch byte is 0x00.
- R2: A 2-byte write at offset 8 selects a key, taken big-endian: lane 0 (bits 7:0) is the high key byte and lane 1 (bits 15:8) is the low key byte. It also resets the cursor to 0. Selector writes of any other size are ignored.
- R3: Each byte moved by a data-register read or write advances the cursor by one, so an access of N bytes advances it by N.
- R4: Every accepted read raises the response valid for exactly one cycle, on the clock after the request. Data lane i (bits 8i+7:8i) holds the blob byte at cursor+i. Lanes beyond the access size read as zero.
- R5: Key 0x0000 is a 4-byte signature holding the bytes 0x43, 0x46, 0x47 and 0x42 in that order, so a 4-byte read from its start returns 0x42474643.
- R6: Key 0x0001 is a 4-byte revision word, stored little-endian, whose value is zero.
- R7: Bytes read past the end of a blob, and every byte of an unknown key, read as 0x00.
- R8: Key 0x0020 is a 16-byte writable scratch blob. On a write, lane i is stored at byte cursor+i.
- R9: Data writes to read-only keys, and the bytes of a write that fall past the end of the scratch blob, leave all stored data unchanged.
- R10: Accesses at offsets other than 0 and 8, data accesses with a size code above 3, and reads of the selector all return zero. Such accesses change neither the cursor nor the key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Always high; a request is accepted every cycle |
| req_addr | input | ADDR_W (4) | Byte offset of the register |
| req_size | input | 3 | Size code: 0=1, 1=2, 2=4, 3=8 bytes; codes above 3 are invalid |
| req_wr | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 64 | Write data; lane i is bits 8i+7:8i |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | 64 | Read response data |

## Verification
The in-RTL properties assume the request inputs stay low while reset is held, since several of them look one cycle back at the request through $past. The cursor step property is also limited to cursor values well below saturation. The bench drives every request on the falling clock edge and deasserts valid during reset. Its cursor never comes near the saturation limit, because each selector write rewinds the cursor long before that. Illegal offsets and size codes go through the normal request port, so the properties see them the same way they see legal traffic.

// File: rtl/cfgblob_pkg.sv
package cfgblob_pkg;
  localparam int unsigned LANES = 8;
  localparam logic [15:0] KEY_SIG     = 16'h0000;
  localparam logic [15:0] KEY_REV     = 16'h0001;
  localparam logic [15:0] KEY_SCRATCH = 16'h0020;

  // size code to byte count, zero for an invalid code
  function automatic logic [3:0] size_bytes(input logic [2:0] code);
    case (code)
      3'd0:    size_bytes = 4'd1;
      3'd1:    size_bytes = 4'd2;
      3'd2:    size_bytes = 4'd4;
      3'd3:    size_bytes = 4'd8;
      default: size_bytes = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/cfgblob_decode.sv
module cfgblob_decode #(
  parameter int ADDR_W   = 4,
  parameter int DATA_OFF = 0,
  parameter int SEL_OFF  = 8
) (
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic              req_wr,
  output logic              sel_wr,
  output logic              data_rd,
  output logic              data_wr,
  output logic              any_rd,
  output logic [3:0]        nbytes
);
  import cfgblob_pkg::*;

  logic at_data, at_sel, size_ok;

  always_comb begin
    nbytes  = size_bytes(req_size);
    size_ok = (nbytes != 4'd0);
    at_data = (req_addr == ADDR_W'(DATA_OFF));
    at_sel  = (req_addr == ADDR_W'(SEL_OFF));
    sel_wr  = req_valid && req_wr && at_sel && (req_size == 3'd1);
    data_rd = req_valid && !req_wr && at_data && size_ok;
    data_wr = req_valid && req_wr && at_data && size_ok;
    any_rd  = req_valid && !req_wr;
  end
endmodule

// File: rtl/cfgblob_cursor.sv
module cfgblob_cursor #(
  parameter int CUR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_wr,
  input  logic [15:0]      sel_key,
  input  logic             data_acc,
  input  logic [3:0]       nbytes,
  output logic [15:0]      key_q,
  output logic [CUR_W-1:0] cur_q
);
  localparam logic [CUR_W-1:0] CUR_MAX    = {CUR_W{1'b1}};
  localparam logic [CUR_W-1:0] STEP_LIMIT = CUR_W'((1 << CUR_W) - 9);

  logic [CUR_W:0] sum;

  always_comb sum = {1'b0, cur_q} + (CUR_W+1)'(nbytes);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q <= 16'h0000;
      cur_q <= '0;
    end else if (sel_wr) begin
      key_q <= sel_key;
      cur_q <= '0;
    end else if (data_acc) begin
      cur_q <= sum[CUR_W] ? CUR_MAX : sum[CUR_W-1:0];
    end
  end

  AST_SEL_REWINDS: assert property (@(posedge clk) disable iff (rst)
    sel_wr |=> (cur_q == '0) && (key_q == $past(sel_key))); // R2

  AST_CURSOR_STEP: assert property (@(posedge clk) disable iff (rst)
    (data_acc && !sel_wr && cur_q < STEP_LIMIT)
      |=> cur_q == CUR_W'($past(cur_q) + CUR_W'($past(nbytes)))); // R3

  AST_CURSOR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!sel_wr && !data_acc) |=> ($stable(cur_q) && $stable(key_q))); // R10
endmodule

// File: rtl/cfgblob_store.sv
module cfgblob_store #(
  parameter int          CUR_W       = 8,
  parameter int          SCRATCH_LEN = 16,
  parameter logic [31:0] SIGNATURE   = 32'h43464742,
  parameter logic [31:0] REVISION    = 32'h00000000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [15:0]      key,
  input  logic [CUR_W-1:0] cur,
  input  logic [3:0]       nbytes,
  input  logic             data_wr,
  input  logic [63:0]      wdata,
  output logic [63:0]      rd_bytes
);
  import cfgblob_pkg::*;

  localparam int IDX_W  = CUR_W + 1;
  localparam int SIDX_W = $clog2(SCRATCH_LEN);

  logic [SCRATCH_LEN-1:0][7:0] scratch_q;
  logic [IDX_W-1:0]            idx [LANES];
  logic [LANES-1:0]            lane_en;
  logic [7:0]                  sig_b [4];
  logic [7:0]                  rev_b [4];
  logic                        scr_wr;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      sig_b[k] = SIGNATURE[8*(3-k) +: 8];
      rev_b[k] = REVISION[8*k +: 8];
    end
    scr_wr = data_wr && (key == KEY_SCRATCH);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] b;
    always_comb begin
      idx[i]     = IDX_W'(cur) + IDX_W'(i);
      lane_en[i] = (4'(i) < nbytes);
      b = 8'h00;
      if (lane_en[i]) begin
        case (key)
          KEY_SIG:     if (idx[i] < IDX_W'(4)) b = sig_b[idx[i][1:0]];
          KEY_REV:     if (idx[i] < IDX_W'(4)) b = rev_b[idx[i][1:0]];
          KEY_SCRATCH: if (idx[i] < IDX_W'(SCRATCH_LEN)) b = scratch_q[idx[i][SIDX_W-1:0]];
          default:     b = 8'h00;
        endcase
      end
      rd_bytes[8*i +: 8] = b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scratch_q <= '0;
    end else if (scr_wr) begin
      for (int j = 0; j < SCRATCH_LEN; j++) begin
        for (int i = 0; i < LANES; i++) begin
          if (lane_en[i] && idx[i] == IDX_W'(j)) scratch_q[j] <= wdata[8*i +: 8];
        end
      end
    end
  end

  AST_RO_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    !(data_wr && key == KEY_SCRATCH) |=> $stable(scratch_q)); // R9

  AST_TAIL_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    (data_wr && IDX_W'(cur) >= IDX_W'(SCRATCH_LEN)) |=> $stable(scratch_q)); // R9
endmodule

// File: rtl/cfgblob_port.sv
module cfgblob_port #(
  parameter int          ADDR_W      = 4,
  parameter int          DATA_OFF    = 0,
  parameter int          SEL_OFF     = 8,
  parameter int          CUR_W       = 8,
  parameter int          SCRATCH_LEN = 16,
  parameter logic [31:0] SIGNATURE   = 32'h43464742,
  parameter logic [31:0] REVISION    = 32'h00000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic              req_wr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata
);
  logic             sel_wr, data_rd, data_wr, any_rd;
  logic [3:0]       nbytes;
  logic [15:0]      key_q;
  logic [CUR_W-1:0] cur_q;
  logic [63:0]      rd_bytes;

  assign req_ready = 1'b1;

  cfgblob_decode #(.ADDR_W(ADDR_W), .DATA_OFF(DATA_OFF), .SEL_OFF(SEL_OFF)) u_decode (
    .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size), .req_wr(req_wr),
    .sel_wr(sel_wr), .data_rd(data_rd), .data_wr(data_wr), .any_rd(any_rd), .nbytes(nbytes)
  );

  cfgblob_cursor #(.CUR_W(CUR_W)) u_cursor (
    .clk(clk), .rst(rst), .sel_wr(sel_wr),
    .sel_key({req_wdata[7:0], req_wdata[15:8]}),
    .data_acc(data_rd || data_wr), .nbytes(nbytes),
    .key_q(key_q), .cur_q(cur_q)
  );

  cfgblob_store #(.CUR_W(CUR_W), .SCRATCH_LEN(SCRATCH_LEN),
                  .SIGNATURE(SIGNATURE), .REVISION(REVISION)) u_store (
    .clk(clk), .rst(rst), .key(key_q), .cur(cur_q), .nbytes(nbytes),
    .data_wr(data_wr), .wdata(req_wdata), .rd_bytes(rd_bytes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= any_rd;
      rsp_rdata <= data_rd ? rd_bytes : 64'h0;
    end
  end

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_wr) |=> rsp_valid); // R4

  AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_wr)); // R4

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_size) == 3'd0) |-> rsp_rdata[63:8] == 56'h0); // R4

  AST_OFF_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_addr) != ADDR_W'(DATA_OFF)) |-> rsp_rdata == 64'h0); // R10
endmodule

// File: tb/cfgblob_port_tb.sv
module cfgblob_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_addr = '0;
  logic [2:0]  req_size = '0;
  logic        req_wr = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] d;
    int          at;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cfgblob_port u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_wr(req_wr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // monitor: pops the scoreboard as responses arrive
  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid) begin
        checks++;
        if (sb.size() == 0) begin
          failures++;
          $display("FAIL R4 unexpected response: got %h expected none", rsp_rdata);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (rsp_rdata !== e.d || cyc != e.at + 1) begin
            failures++;
            $display("FAIL %s: got %h at cycle %0d expected %h at cycle %0d",
                     e.tag, rsp_rdata, cyc, e.d, e.at + 1);
          end
        end
      end else if (sb.size() > 0 && cyc > sb[0].at + 1) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        failures++;
        $display("FAIL %s R4: no response, got none expected %h", e.tag, e.d);
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [2:0] s, input logic [63:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_wr = 1'b0; req_addr = a; req_size = s; req_wdata = '0;
    e.d = d; e.at = cyc; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wr(input logic [3:0] a, input logic [2:0] s, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_wr = 1'b1; req_addr = a; req_size = s; req_wdata = d;
  endtask

  task automatic sel(input logic [15:0] key);
    wr(4'd8, 3'd1, {48'h0, key[7:0], key[15:8]});
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0; req_wr = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state: key 0, cursor 0, quiet response
    checks++;
    if (rsp_valid !== 1'b0) begin
      failures++; $display("FAIL R1 rsp_valid after reset: got %b expected 0", rsp_valid);
    end
    rd(4'd0, 3'd2, 64'h42474643, "R1 default key/cursor");
    sel(16'h0020);
    rd(4'd0, 3'd3, 64'h0, "R1 scratch zero");
    rd(4'd0, 3'd3, 64'h0, "R1 scratch zero hi");

    // R5 R3 signature bytewise, then R7 past end
    sel(16'h0000);
    rd(4'd0, 3'd0, 64'h43, "R5 sig b0");
    rd(4'd0, 3'd0, 64'h46, "R5 sig b1");
    rd(4'd0, 3'd0, 64'h47, "R5 sig b2");
    rd(4'd0, 3'd0, 64'h42, "R5 sig b3");
    rd(4'd0, 3'd0, 64'h0,  "R7 sig past end");

    // R6 revision
    sel(16'h0001);
    rd(4'd0, 3'd2, 64'h0, "R6 revision");
    rd(4'd0, 3'd0, 64'h0, "R7 revision past end");

    // R8 scratch writes and readback
    sel(16'h0020);
    wr(4'd0, 3'd3, 64'h8877665544332211);
    wr(4'd0, 3'd2, 64'h00000000DDCCBBAA);
    sel(16'h0020);
    rd(4'd0, 3'd3, 64'h8877665544332211, "R8 scratch 0-7");
    rd(4'd0, 3'd1, 64'hBBAA, "R3 cursor 8");
    rd(4'd0, 3'd1, 64'hDDCC, "R3 cursor 10");
    rd(4'd0, 3'd2, 64'h0, "R8 unwritten 12-15");
    rd(4'd0, 3'd0, 64'h0, "R7 scratch past end");
    wr(4'd0, 3'd2, 64'hEEEEEEEE);
    sel(16'h0020);
    rd(4'd0, 3'd3, 64'h8877665544332211, "R9 past-end write 0-7");
    rd(4'd0, 3'd3, 64'h00000000DDCCBBAA, "R9 past-end write 8-15");

    // R9 write straddling the end
    sel(16'h0020);
    rd(4'd0, 3'd3, 64'h8877665544332211, "R8 skip");
    rd(4'd0, 3'd2, 64'hDDCCBBAA, "R8 skip2");
    wr(4'd0, 3'd3, 64'h0102030405060708);
    sel(16'h0020);
    rd(4'd0, 3'd3, 64'h8877665544332211, "R9 straddle lo");
    rd(4'd0, 3'd3, 64'h05060708DDCCBBAA, "R9 straddle hi");

    // R9 read-only key
    sel(16'h0000);
    wr(4'd0, 3'd2, 64'hFFFFFFFF);
    sel(16'h0000);
    rd(4'd0, 3'd2, 64'h42474643, "R9 signature intact");

    // R7 unknown key, R2 byte order
    sel(16'h1234);
    rd(4'd0, 3'd2, 64'h0, "R7 unknown key");
    sel(16'h2000);
    rd(4'd0, 3'd1, 64'h0, "R2 swapped key is unknown");

    // R10 bad offset / size, R2 wrong selector size
    sel(16'h0000);
    rd(4'd4, 3'd2, 64'h0, "R10 bad offset");
    rd(4'd0, 3'd4, 64'h0, "R10 bad size");
    rd(4'd8, 3'd1, 64'h0, "R10 selector read");
    wr(4'd0, 3'd5, 64'hFF);
    wr(4'd4, 3'd0, 64'hFF);
    rd(4'd0, 3'd0, 64'h43, "R10 cursor unchanged");
    wr(4'd8, 3'd0, 64'h20);
    rd(4'd0, 3'd0, 64'h46, "R2 1-byte selector ignored");

    idle(4);
    // R4 no response without reads
    checks++;
    if (rsp_valid !== 1'b0 || sb.size() != 0) begin
      failures++;
      $display("FAIL R4 idle: got valid=%b pending=%0d expected 0/0", rsp_valid, sb.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule